// File: doc/BRIEF.md
# Video Frame Geometry Meter

This block watches the horizontal and vertical sync lines of a parallel video stream, clocked by the pixel clock, and works out the raster geometry of each frame. It reports five figures: the full line period in pixel clocks, the part of the line where horizontal sync is inactive, the horizontal sync pulse width, the number of lines in a frame, and the vertical sync pulse width in lines. It uses no data-enable input. Every figure comes from sync edges alone.

Each sync input has its own polarity select, so the same logic serves active-high and active-low sources. After normalisation, the leading edge of horizontal sync opens a line and the leading edge of vertical sync opens a frame. The figures of a frame that has been seen in full are loaded into the result outputs at the start of the next frame, together with a one-cycle valid strobe. A counter that runs past its range stops at its maximum and raises an overflow flag that is reported with that frame. A frame that may be partial is never reported. This covers the frame in progress at reset and the frame in progress when a polarity select changes.

Top module: `vfg_meter`

## Requirements
- R1: `line_total` reports the number of pixel clocks between the two horizontal sync leading edges that bound the last line completed in the reported frame.
- R2: `hs_width` reports how many pixel clocks horizontal sync was active in that same line. The count includes the clock of its leading edge.
- R3: `line_active` reports how many pixel clocks horizontal sync was inactive in that same line. When no overflow is flagged, `line_active + hs_width == line_total`.
- R4: `frame_lines` reports the number of horizontal sync leading edges in the frame. Counting starts with an edge that coincides with the opening vertical sync leading edge and stops short of the next vertical sync leading edge.
- R5: `vs_width` reports the number of horizontal sync leading edges that occur while vertical sync is active in the frame. It never exceeds `frame_lines`.
- R6: Each of `hs_pol` and `vs_pol` sets the polarity of its own sync input: 0 means active-high and 1 means active-low.
- R7: The results change only at the start of a following frame. This happens two clocks after the vertical sync leading edge has been sampled, and at that point `meas_valid` is high for exactly one clock. Between strobes all result outputs hold their values.
- R8: No results are reported for the frame in progress at reset or when either polarity select changes. A sync edge that appears only because of a polarity change is ignored. After such a change, `meas_valid` stays low on the second clock.
- R9: Every count saturates at 2047. `meas_ovf` is set with a frame's results if any counter tried to exceed 2047 during that frame. A line of exactly 2047 clocks reads 2047 with no overflow.
- R10: After reset, all result outputs read 0 and `meas_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hsync_in | input | 1 | Horizontal sync, raw level |
| vsync_in | input | 1 | Vertical sync, raw level |
| hs_pol | input | 1 | Horizontal sync polarity: 0 active-high, 1 active-low |
| vs_pol | input | 1 | Vertical sync polarity: 0 active-high, 1 active-low |
| line_total | output | 11 | Line period in pixel clocks |
| line_active | output | 11 | Clocks with horizontal sync inactive in that line |
| hs_width | output | 11 | Horizontal sync pulse width in clocks |
| frame_lines | output | 11 | Lines per frame |
| vs_width | output | 11 | Vertical sync pulse width in lines |
| meas_valid | output | 1 | One-clock strobe when new results are loaded |
| meas_ovf | output | 1 | A counter saturated during the reported frame |

## Verification
The properties assume that both sync inputs are synchronous to the pixel clock and that each frame lasts more than one clock. They also assume that polarity selects change only while the meter can afford to lose the frame in progress. The stimulus changes every input on the falling clock edge. It changes polarity only together with the first pixel of a new frame, and every frame it builds has vertical sync opening on a line start. Overflow is reached by lines longer than 2047 clocks, and the exact boundary by a line of 2047 clocks.

// File: rtl/vfg_pkg.sv
package vfg_pkg;

  // Default counter width: enough for 2047 pixels or lines.
  localparam int VFG_CNT_W = 11;

  // Counter slots inside the meter.
  localparam int CI_TOT = 0;
  localparam int CI_HSW = 1;
  localparam int CI_ACT = 2;
  localparam int CI_LIN = 3;
  localparam int CI_VSW = 4;
  localparam int NCNT   = 5;
  // The first NLINE slots are per-line figures captured at each line start.
  localparam int NLINE  = 3;

  // Sync slots in the edge detector.
  localparam int SI_HS = 0;
  localparam int SI_VS = 1;
  localparam int NSYNC = 2;

  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_RUN  = 1'b1
  } vfg_state_e;

endpackage

// File: rtl/vfg_sync_edge.sv
module vfg_sync_edge #(
  parameter int NSIG = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSIG-1:0] raw,
  input  logic [NSIG-1:0] pol,
  output logic [NSIG-1:0] lvl,
  output logic [NSIG-1:0] lead,
  output logic            pol_chg_d
);

  logic [NSIG-1:0] pol_q;
  logic            chg_q;
  logic            chg_d;

  for (genvar g = 0; g < NSIG; g++) begin : g_sig
    logic norm_d;
    logic cur_q;
    logic old_q;
    logic pol_r;

    assign norm_d = raw[g] ^ pol[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_q <= 1'b0;
        old_q <= 1'b0;
        pol_r <= 1'b0;
      end else begin
        cur_q <= norm_d;
        old_q <= cur_q;
        pol_r <= pol[g];
      end
    end

    assign lvl[g]   = cur_q;
    assign pol_q[g] = pol_r;
    // Edges seen in the clock right after a polarity change are artefacts.
    assign lead[g]  = cur_q & ~old_q & ~chg_q;
  end

  assign chg_d = |(pol ^ pol_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_q <= 1'b0;
    end else begin
      chg_q <= chg_d;
    end
  end

  assign pol_chg_d = chg_q;

endmodule

// File: rtl/vfg_sat_cnt.sv
module vfg_sat_cnt #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld_one,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         ovf_ev
);

  localparam logic [W-1:0] CMAX = '1;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    ovf_ev = 1'b0;
    if (clr) begin
      cnt_d = {{(W-1){1'b0}}, ld_one};
    end else if (inc) begin
      if (cnt_q == CMAX) begin
        ovf_ev = 1'b1;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
  end

  assign cnt_en = clr | inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/vfg_meter.sv
module vfg_meter
  import vfg_pkg::*;
#(
  parameter int CNT_W = VFG_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic             hs_pol,
  input  logic             vs_pol,
  output logic [CNT_W-1:0] line_total,
  output logic [CNT_W-1:0] line_active,
  output logic [CNT_W-1:0] hs_width,
  output logic [CNT_W-1:0] frame_lines,
  output logic [CNT_W-1:0] vs_width,
  output logic             meas_valid,
  output logic             meas_ovf
);

  // Reset: asserted asynchronously, released on the second clock.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_core_n = rst_sync_q[1];

  // Polarity normalisation and leading-edge detection.
  logic [NSYNC-1:0] sync_raw;
  logic [NSYNC-1:0] sync_pol;
  logic [NSYNC-1:0] sync_lvl;
  logic [NSYNC-1:0] sync_lead;
  logic             pol_chg;
  logic             hs_lvl;
  logic             vs_lvl;
  logic             hs_lead;
  logic             vs_lead;

  assign sync_raw[SI_HS] = hsync_in;
  assign sync_raw[SI_VS] = vsync_in;
  assign sync_pol[SI_HS] = hs_pol;
  assign sync_pol[SI_VS] = vs_pol;

  vfg_sync_edge #(.NSIG(NSYNC)) u_edge (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .raw       (sync_raw),
    .pol       (sync_pol),
    .lvl       (sync_lvl),
    .lead      (sync_lead),
    .pol_chg_d (pol_chg)
  );

  assign hs_lvl  = sync_lvl[SI_HS];
  assign vs_lvl  = sync_lvl[SI_VS];
  assign hs_lead = sync_lead[SI_HS];
  assign vs_lead = sync_lead[SI_VS];

  // Counter controls.
  logic [NCNT-1:0]  c_clr;
  logic [NCNT-1:0]  c_ld;
  logic [NCNT-1:0]  c_inc;
  logic [NCNT-1:0]  c_ovf;
  logic [CNT_W-1:0] c_val [NCNT];

  always_comb begin
    c_clr[CI_TOT] = hs_lead;
    c_ld[CI_TOT]  = 1'b1;
    c_inc[CI_TOT] = 1'b1;

    c_clr[CI_HSW] = hs_lead;
    c_ld[CI_HSW]  = 1'b1;
    c_inc[CI_HSW] = hs_lvl;

    c_clr[CI_ACT] = hs_lead;
    c_ld[CI_ACT]  = 1'b0;
    c_inc[CI_ACT] = ~hs_lvl;

    c_clr[CI_LIN] = vs_lead;
    c_ld[CI_LIN]  = hs_lead;
    c_inc[CI_LIN] = hs_lead;

    c_clr[CI_VSW] = vs_lead;
    c_ld[CI_VSW]  = hs_lead;
    c_inc[CI_VSW] = hs_lead & vs_lvl;
  end

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    vfg_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .clr    (c_clr[i]),
      .ld_one (c_ld[i]),
      .inc    (c_inc[i]),
      .cnt    (c_val[i]),
      .ovf_ev (c_ovf[i])
    );
  end

  // Per-line capture, with bypass so a coincident frame edge sees the line just closed.
  logic [CNT_W-1:0] line_q [NLINE];
  logic [CNT_W-1:0] line_d [NLINE];

  always_comb begin
    for (int i = 0; i < NLINE; i++) begin
      line_d[i] = hs_lead ? c_val[i] : line_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      for (int i = 0; i < NLINE; i++) begin
        line_q[i] <= '0;
      end
    end else if (hs_lead) begin
      for (int i = 0; i < NLINE; i++) begin
        line_q[i] <= line_d[i];
      end
    end
  end

  // Frame state, overflow accumulation, result registers.
  vfg_state_e       st_q;
  vfg_state_e       st_d;
  logic             ovf_acc_q;
  logic             ovf_acc_d;
  logic             ovf_now;
  logic             latch;
  logic [CNT_W-1:0] res_q [NCNT];
  logic [CNT_W-1:0] res_d [NCNT];
  logic             rovf_d;
  logic             rovf_q;
  logic             valid_q;

  assign ovf_now = |c_ovf;
  assign latch   = vs_lead & (st_q == ST_RUN);

  always_comb begin
    st_d = st_q;
    if (pol_chg) begin
      st_d = ST_WAIT;
    end else if (vs_lead) begin
      st_d = ST_RUN;
    end

    ovf_acc_d = vs_lead ? 1'b0 : (ovf_acc_q | ovf_now);
    rovf_d    = ovf_acc_q | ovf_now;

    for (int i = 0; i < NCNT; i++) begin
      res_d[i] = (i < NLINE) ? line_d[i] : c_val[i];
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q      <= ST_WAIT;
      ovf_acc_q <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      st_q      <= st_d;
      ovf_acc_q <= ovf_acc_d;
      valid_q   <= latch;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      for (int i = 0; i < NCNT; i++) begin
        res_q[i] <= '0;
      end
      rovf_q <= 1'b0;
    end else if (latch) begin
      for (int i = 0; i < NCNT; i++) begin
        res_q[i] <= res_d[i];
      end
      rovf_q <= rovf_d;
    end
  end

  assign line_total  = res_q[CI_TOT];
  assign hs_width    = res_q[CI_HSW];
  assign line_active = res_q[CI_ACT];
  assign frame_lines = res_q[CI_LIN];
  assign vs_width    = res_q[CI_VSW];
  assign meas_valid  = valid_q;
  assign meas_ovf    = rovf_q;

endmodule

// File: rtl/vfg_meter_chk.sv
module vfg_meter_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hs_pol,
  input logic             vs_pol,
  input logic [CNT_W-1:0] line_total,
  input logic [CNT_W-1:0] line_active,
  input logic [CNT_W-1:0] hs_width,
  input logic [CNT_W-1:0] frame_lines,
  input logic [CNT_W-1:0] vs_width,
  input logic             meas_valid,
  input logic             meas_ovf
);

  // R7: strobe lasts one clock
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |=> !meas_valid);

  // R7: results hold between strobes
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_valid |-> $stable({line_total, line_active, hs_width, frame_lines, vs_width, meas_ovf}));

  // R3: active part and pulse width make up the line when nothing saturated
  assert_line_split_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && !meas_ovf) |->
      (({1'b0, line_active} + {1'b0, hs_width}) == {1'b0, line_total}));

  // R5: vertical pulse never longer than the frame
  assert_vs_fits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |-> (vs_width <= frame_lines));

  // R8: a polarity change suppresses reporting
  assert_pol_discard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((hs_pol != $past(hs_pol)) || (vs_pol != $past(vs_pol))) |-> ##2 !meas_valid);

endmodule

bind vfg_meter vfg_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hs_pol      (hs_pol),
  .vs_pol      (vs_pol),
  .line_total  (line_total),
  .line_active (line_active),
  .hs_width    (hs_width),
  .frame_lines (frame_lines),
  .vs_width    (vs_width),
  .meas_valid  (meas_valid),
  .meas_ovf    (meas_ovf)
);

// File: tb/vfg_meter_tb.sv
`timescale 1ns/1ps
module vfg_meter_tb;

  localparam int W    = 11;
  localparam int MAXV = 2047;

  logic         clk;
  logic         rst_n;
  logic         hsync_in;
  logic         vsync_in;
  logic         hs_pol;
  logic         vs_pol;
  logic [W-1:0] line_total;
  logic [W-1:0] line_active;
  logic [W-1:0] hs_width;
  logic [W-1:0] frame_lines;
  logic [W-1:0] vs_width;
  logic         meas_valid;
  logic         meas_ovf;

  int checks;
  int errors;
  bit done;

  vfg_meter #(.CNT_W(W)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .hsync_in    (hsync_in),
    .vsync_in    (vsync_in),
    .hs_pol      (hs_pol),
    .vs_pol      (vs_pol),
    .line_total  (line_total),
    .line_active (line_active),
    .hs_width    (hs_width),
    .frame_lines (frame_lines),
    .vs_width    (vs_width),
    .meas_valid  (meas_valid),
    .meas_ovf    (meas_ovf)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  // Behavioural reference model, stepped on every rising edge.
  int  rcnt;
  int  m_pc, m_hw, m_ac, m_ln, m_vw;
  int  l_tot, l_hw, l_ac;
  int  e_tot, e_hw, e_ac, e_ln, e_vw;
  bit  e_val, e_ovf;
  bit  s_hs, s_hs_p, s_vs, s_vs_p;
  bit  p_h, p_h_p, p_v, p_v_p;
  bit  run, oacc;

  task automatic model_clear();
    m_pc = 0; m_hw = 0; m_ac = 0; m_ln = 0; m_vw = 0;
    l_tot = 0; l_hw = 0; l_ac = 0;
    e_tot = 0; e_hw = 0; e_ac = 0; e_ln = 0; e_vw = 0;
    e_val = 0; e_ovf = 0;
    s_hs = 0; s_hs_p = 0; s_vs = 0; s_vs_p = 0;
    p_h = 0; p_h_p = 0; p_v = 0; p_v_p = 0;
    run = 0; oacc = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      rcnt = 0;
      model_clear();
    end else if (rcnt < 2) begin
      rcnt++;
      model_clear();
    end else begin
      bit chg, hl, vl, ev;
      int n_pc, n_hw, n_ac, n_ln, n_vw;
      int c_tot, c_hw, c_ac;
      chg = (p_h != p_h_p) || (p_v != p_v_p);
      hl  = s_hs && !s_hs_p && !chg;
      vl  = s_vs && !s_vs_p && !chg;
      n_pc = hl ? 1 : m_pc + 1;
      n_hw = hl ? 1 : m_hw + int'(s_hs);
      n_ac = hl ? 0 : m_ac + int'(!s_hs);
      n_ln = vl ? int'(hl) : m_ln + int'(hl);
      n_vw = vl ? int'(hl) : m_vw + int'(hl && s_vs);
      ev = (n_pc > MAXV) || (n_hw > MAXV) || (n_ac > MAXV) || (n_ln > MAXV) || (n_vw > MAXV);
      c_tot = hl ? sat(m_pc) : l_tot;
      c_hw  = hl ? sat(m_hw) : l_hw;
      c_ac  = hl ? sat(m_ac) : l_ac;
      e_val = vl && run;
      if (vl && run) begin
        e_tot = c_tot; e_hw = c_hw; e_ac = c_ac;
        e_ln = sat(m_ln); e_vw = sat(m_vw);
        e_ovf = oacc || ev;
      end
      oacc = vl ? 1'b0 : (oacc || ev);
      if (chg) run = 1'b0;
      else if (vl) run = 1'b1;
      l_tot = c_tot; l_hw = c_hw; l_ac = c_ac;
      m_pc = n_pc; m_hw = n_hw; m_ac = n_ac; m_ln = n_ln; m_vw = n_vw;
      s_hs_p = s_hs; s_hs = hsync_in ^ hs_pol;
      s_vs_p = s_vs; s_vs = vsync_in ^ vs_pol;
      p_h_p = p_h; p_h = hs_pol;
      p_v_p = p_v; p_v = vs_pol;
    end
  end

  // Compare every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 line_total vs model", int'(line_total), e_tot);
      chk("R2 hs_width vs model", int'(hs_width), e_hw);
      chk("R3 line_active vs model", int'(line_active), e_ac);
      chk("R4 frame_lines vs model", int'(frame_lines), e_ln);
      chk("R5 vs_width vs model", int'(vs_width), e_vw);
      chk("R7 meas_valid vs model", int'(meas_valid), int'(e_val));
      chk("R9 meas_ovf vs model", int'(meas_ovf), int'(e_ovf));
    end
  end

  int vcnt;

  task automatic drive_frames(input int nf, input int htot, input int hw,
                              input int nl, input int vw, input bit hp, input bit vp);
    vcnt = 0;
    for (int f = 0; f < nf; f++) begin
      for (int l = 0; l < nl; l++) begin
        for (int p = 0; p < htot; p++) begin
          @(negedge clk);
          if (meas_valid) vcnt++;
          hs_pol   = hp;
          vs_pol   = vp;
          hsync_in = (p < hw) ^ hp;
          vsync_in = (l < vw) ^ vp;
        end
      end
    end
  endtask

  task automatic check_geom(input string tag, input int htot, input int hw,
                            input int nl, input int vw, input int ovf);
    chk({tag, " R1 line_total"}, int'(line_total), sat(htot));
    chk({tag, " R2 hs_width"}, int'(hs_width), hw);
    chk({tag, " R3 line_active"}, int'(line_active), htot - hw);
    chk({tag, " R4 frame_lines"}, int'(frame_lines), nl);
    chk({tag, " R5 vs_width"}, int'(vs_width), vw);
    chk({tag, " R9 meas_ovf"}, int'(meas_ovf), ovf);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int h0, a0, w0, l0, v0;
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; hsync_in = 1'b0; vsync_in = 1'b0; hs_pol = 1'b0; vs_pol = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10 reset line_total", int'(line_total), 0);
    chk("R10 reset frame_lines", int'(frame_lines), 0);
    chk("R10 reset meas_valid", int'(meas_valid), 0);
    chk("R10 reset meas_ovf", int'(meas_ovf), 0);

    // R8: frame in progress at reset is not reported
    drive_frames(2, 20, 3, 6, 2, 1'b0, 1'b0);
    chk("R8 one strobe after reset", vcnt, 1);
    check_geom("A", 20, 3, 6, 2, 0);

    // R6: active-low horizontal sync, R8 polarity change drops a frame
    drive_frames(3, 33, 7, 5, 1, 1'b1, 1'b0);
    chk("R8 strobes after hs polarity change", vcnt, 1);
    check_geom("B R6", 33, 7, 5, 1, 0);

    // R6: both active-low, single-clock pulse
    drive_frames(3, 17, 1, 9, 3, 1'b1, 1'b1);
    chk("R8 strobes after vs polarity change", vcnt, 1);
    check_geom("C R6", 17, 1, 9, 3, 0);

    // R9: exactly 2047 clocks, no overflow
    drive_frames(3, 2047, 10, 2, 1, 1'b0, 1'b0);
    check_geom("D R9 boundary", 2047, 10, 2, 1, 0);

    // R9: longer line saturates and flags
    drive_frames(3, 2050, 4, 2, 1, 1'b0, 1'b0);
    chk("R7 strobe every frame without polarity change", vcnt, 3);
    chk("E R9 line_total saturated", int'(line_total), 2047);
    chk("E R9 overflow set", int'(meas_ovf), 1);
    chk("E R2 hs_width", int'(hs_width), 4);
    chk("E R3 line_active", int'(line_active), 2046);

    // R7: no sync edges, results hold
    h0 = int'(line_total); a0 = int'(line_active); w0 = int'(hs_width);
    l0 = int'(frame_lines); v0 = int'(vs_width);
    repeat (60) begin
      @(negedge clk);
      hsync_in = 1'b0;
      vsync_in = 1'b0;
    end
    chk("R7 hold line_total", int'(line_total), h0);
    chk("R7 hold line_active", int'(line_active), a0);
    chk("R7 hold hs_width", int'(hs_width), w0);
    chk("R7 hold frame_lines", int'(frame_lines), l0);
    chk("R7 hold vs_width", int'(vs_width), v0);
    chk("R7 no strobe while idle", int'(meas_valid), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule